// File: doc/BRIEF.md
# Wide Combined Tausworthe Uniform Source

This block feeds an inversion-based sampler with a fresh uniform word on every enabled clock cycle. Inside are two independent combined Tausworthe generators. Each one runs three shift-register recurrences on 32-bit states and XORs the three states together to form a 32-bit word. The two words are joined into a 64-bit vector. The sampler takes its 52-bit magnitude input from the top of that vector and its sign bit from the bottom.

Seeds are fixed at elaboration through parameters. After reset the block stays idle. An init strobe loads the seeds and arms the block. From then on, each cycle with enable high advances all six recurrences by one step. A valid flag marks the cycles whose output word was just produced.

Top module: `taus_urng_top`

## Requirements
- R1: After asynchronous reset, valid_o is 0. All six component states hold their seed values, so x_o and sign_o show the word formed from the seeds.
- R2: A cycle with init_i high reloads all six states with their seeds. valid_o is 0 in the following cycle, even if en_i is high.
- R3: Once an init has been taken, each cycle with en_i high and init_i low advances every component by exactly one step. valid_o is 1 in the following cycle.
- R4: Each component steps as t = ((s << q) ^ s) >> r, then s' = ((s & m) << k) ^ t. The constants are: component 0 uses (q,r,k,m) = (13,19,12,0xFFFFFFFE), component 1 uses (2,25,4,0xFFFFFFF8), and component 2 uses (3,11,17,0xFFFFFFF0).
- R5: A generator's 32-bit word is the XOR of its three component states.
- R6: The 64-bit vector is {word_a, word_b}, with generator A in the upper half. x_o is bits 63:12 of this vector and sign_o is bit 0.
- R7: A cycle with en_i low and init_i low leaves every state, x_o and sign_o unchanged. valid_o is 0 in the following cycle.
- R8: Before the first init after reset, en_i has no effect: states do not move and valid_o stays 0.
- R9: No component ever reaches a state whose masked bits are all zero, so the sequence never locks up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Reload seeds and arm the generators |
| en_i | input | 1 | Advance one step this cycle |
| x_o | output | 52 | Uniform magnitude field |
| sign_o | output | 1 | Sign bit |
| valid_o | output | 1 | Output word is fresh this cycle |

## Verification
The bench drives enable before any init to catch a design that free-runs out of reset. It asserts init together with enable to catch a design that steps instead of reloading. It holds enable low across long gaps to catch a design that drifts or keeps valid high. A run of several thousand random cycles is compared against an independent model of the recurrences. A wrong shift or mask constant, a swapped generator order, or an off-by-one field slice would make x_o or sign_o diverge within a few steps.

// File: rtl/taus_urng_pkg.sv
package taus_urng_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NUM_COMP = 3;

  typedef logic [WORD_W-1:0] word_t;

  // per-component constants: feedback shift, right shift, output shift, mask
  localparam int unsigned Q_TAB [NUM_COMP] = '{13, 2, 3};
  localparam int unsigned R_TAB [NUM_COMP] = '{19, 25, 11};
  localparam int unsigned K_TAB [NUM_COMP] = '{12, 4, 17};
  localparam word_t       M_TAB [NUM_COMP] = '{32'hFFFF_FFFE, 32'hFFFF_FFF8, 32'hFFFF_FFF0};

  function automatic word_t taus_step(word_t s, int unsigned q, int unsigned r,
                                      int unsigned k, word_t m);
    word_t t;
    t = ((s << q) ^ s) >> r;
    return ((s & m) << k) ^ t;
  endfunction
endpackage

// File: rtl/taus_component.sv
module taus_component
  import taus_urng_pkg::*;
#(
  parameter int unsigned Q    = 13,
  parameter int unsigned R    = 19,
  parameter int unsigned K    = 12,
  parameter word_t       MASK = 32'hFFFF_FFFE,
  parameter word_t       SEED = 32'd12345
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  adv_i,
  output word_t state_o
);
  word_t state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (load_i) state_q <= SEED;
    else if (adv_i)  state_q <= taus_step(state_q, Q, R, K, MASK);
  end

  assign state_o = state_q;

  // R7
  state_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(state_q));

  // R9
  no_lockup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(state_q & MASK));
endmodule

// File: rtl/taus_combined.sv
module taus_combined
  import taus_urng_pkg::*;
#(
  parameter logic [NUM_COMP*WORD_W-1:0] SEEDS = {32'd13579, 32'd67890, 32'd12345}
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  adv_i,
  output word_t word_o
);
  word_t comp_st [NUM_COMP];

  for (genvar i = 0; i < NUM_COMP; i++) begin : g_comp
    taus_component #(
      .Q   (Q_TAB[i]),
      .R   (R_TAB[i]),
      .K   (K_TAB[i]),
      .MASK(M_TAB[i]),
      .SEED(SEEDS[i*WORD_W +: WORD_W])
    ) u_comp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load_i),
      .adv_i  (adv_i),
      .state_o(comp_st[i])
    );
  end

  always_comb begin
    word_o = '0;
    for (int i = 0; i < NUM_COMP; i++) word_o = word_o ^ comp_st[i];
  end

  // R2
  load_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (word_o == (SEEDS[0 +: WORD_W] ^ SEEDS[WORD_W +: WORD_W] ^ SEEDS[2*WORD_W +: WORD_W])));
endmodule

// File: rtl/taus_urng_top.sv
module taus_urng_top
  import taus_urng_pkg::*;
#(
  parameter logic [NUM_COMP*WORD_W-1:0] SEEDS_A = {32'd13579, 32'd67890, 32'd12345},
  parameter logic [NUM_COMP*WORD_W-1:0] SEEDS_B = {32'd99991, 32'd11111, 32'd24680},
  parameter int unsigned X_W = 52
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           init_i,
  input  logic           en_i,
  output logic [X_W-1:0] x_o,
  output logic           sign_o,
  output logic           valid_o
);
  localparam int unsigned CAT_W = 2 * WORD_W;

  logic  armed_q, valid_q, adv;
  word_t word_a, word_b;
  logic [CAT_W-1:0] cat;

  assign adv = armed_q && en_i && !init_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      if (init_i) armed_q <= 1'b1;
      valid_q <= adv;
    end
  end

  taus_combined #(.SEEDS(SEEDS_A)) u_gen_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(init_i), .adv_i(adv), .word_o(word_a)
  );
  taus_combined #(.SEEDS(SEEDS_B)) u_gen_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(init_i), .adv_i(adv), .word_o(word_b)
  );

  assign cat     = {word_a, word_b};
  assign x_o     = cat[CAT_W-1 -: X_W];
  assign sign_o  = cat[0];
  assign valid_o = valid_q;

  // R3
  valid_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(en_i && !init_i));

  // R2
  init_clears_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> !valid_o);

  // R8
  idle_before_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> !valid_o);

  // R7
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !init_i) |=> ($stable(x_o) && $stable(sign_o) && !valid_o));
endmodule

// File: tb/taus_urng_top_tb.sv
module taus_urng_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b0;
  logic en = 1'b0;
  logic [51:0] x;
  logic sign, valid;

  int unsigned vectors = 0;
  int unsigned miscompares = 0;
  logic [31:0] ms [6];
  logic m_armed, m_valid;
  bit done = 0;

  localparam logic [31:0] SD [6] = '{32'd12345, 32'd67890, 32'd13579,
                                     32'd24680, 32'd11111, 32'd99991};

  always #4 clk = ~clk;

  taus_urng_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .en_i(en),
    .x_o(x), .sign_o(sign), .valid_o(valid)
  );

  // R4 model step
  function automatic logic [31:0] mstep(logic [31:0] s, int c);
    logic [31:0] t;
    case (c)
      0: begin t = ((s << 13) ^ s) >> 19; return ((s & 32'hFFFFFFFE) << 12) ^ t; end
      1: begin t = ((s << 2)  ^ s) >> 25; return ((s & 32'hFFFFFFF8) << 4)  ^ t; end
      default: begin t = ((s << 3) ^ s) >> 11; return ((s & 32'hFFFFFFF0) << 17) ^ t; end
    endcase
  endfunction

  // R5, R6 expected vector
  function automatic logic [63:0] mcat();
    return {ms[0] ^ ms[1] ^ ms[2], ms[3] ^ ms[4] ^ ms[5]};
  endfunction

  task automatic check(string req);
    logic [63:0] c = mcat();
    vectors++;
    if (x !== c[63:12] || sign !== c[0] || valid !== m_valid) begin
      miscompares++;
      $display("FAIL %s: x=%h sign=%b valid=%b expected x=%h sign=%b valid=%b",
               req, x, sign, valid, c[63:12], c[0], m_valid);
    end
  endtask

  task automatic cycle(logic i, logic e, string req);
    logic adv;
    init = i; en = e;
    @(posedge clk);
    adv = m_armed && e && !i;
    for (int k = 0; k < 6; k++) begin
      if (i) ms[k] = SD[k];
      else if (adv) ms[k] = mstep(ms[k], k % 3);
    end
    if (i) m_armed = 1'b1;
    m_valid = adv;
    @(negedge clk);
    check(req);
  endtask

  initial begin
    for (int k = 0; k < 6; k++) ms[k] = SD[k];
    m_armed = 1'b0; m_valid = 1'b0;
    void'($urandom(32'd2024));
    #20;
    @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    // R8: enable ignored before init
    for (int n = 0; n < 5; n++) cycle(1'b0, 1'b1, "R8");
    // R2: init with enable high still reloads
    cycle(1'b1, 1'b1, "R2");
    // R3, R4, R5, R6: steady stepping
    for (int n = 0; n < 50; n++) cycle(1'b0, 1'b1, "R3");
    // R7: long hold
    for (int n = 0; n < 20; n++) cycle(1'b0, 1'b0, "R7");
    // R2: reload mid-run
    cycle(1'b1, 1'b0, "R2");
    for (int n = 0; n < 10; n++) cycle(1'b0, 1'b1, "R4");
    // mixed random run
    for (int n = 0; n < 5000; n++) begin
      logic ri = ($urandom % 100) == 0;
      logic re = ($urandom % 4) != 0;
      cycle(ri, re, "R6");
    end
    // R9: component states seen through outputs stay live
    for (int n = 0; n < 8; n++) cycle(1'b0, 1'b1, "R9");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule